// File: doc/BRIEF.md
# SPI Master with Transmit and Receive Queues

This block is an SPI master that software drives through a small 32-bit register window. Words written to the data-out register are placed in a transmit queue. While the hold bit in the control register is set, nothing is shifted. Software can therefore load a whole burst first and then clear the hold. From that point the shift engine sends every queued word, one after the next, and stores one received word in the receive queue for each word it sends.

The control register selects the serial clock polarity and sampling phase, the bit order on the wire, and an internal loopback path. The serial clock rate is set only by a build parameter. Active-low select lines are driven in one of two ways. In manual mode they copy the select register directly. In automatic mode they copy it only while words are queued or shifting, and otherwise all lines are released high.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, control reads 0x100 (hold set), status reads 0x05, select reads 0xFFFFFFFF, every select pin is high and the serial clock is low.
- R2: Control bit positions are: loopback 0, enable 1, master 2, polarity 3, phase 4, transmit flush 5, receive flush 6, manual select 7, hold 8, LSB-first 9. A write of 0x3FF reads back as 0x39F. Status bits are: receive empty 0, receive full 1, transmit empty 2, transmit full 3, and bit 4 (fault) always reads 0.
- R3: While the hold bit (0x100) is set, queued words stay queued, the serial clock does not toggle and transmit empty (status bit 2) reads 0.
- R4: Transmit full (status bit 3) is correct on the first read after each write to offset 0x68. Writing until it sets takes exactly FIFO_DEPTH writes.
- R5: Once hold is cleared with enable and master set, all queued words are shifted back to back, and the receive queue at offset 0x6C returns one word per word sent, in the same order.
- R6: The serial clock idles at the polarity bit. Input is sampled, and output is stable, on the rising edge when polarity equals phase and on the falling edge otherwise. Exactly WORD_W sampling edges occur per word.
- R7: The most significant bit goes first on the wire by default. With LSB-first (0x200) the least significant bit goes first. Received bits are reassembled in the same order.
- R8: With loopback (0x01) set, the received word equals the sent word whatever the input pin carries.
- R9: Each serial clock half period lasts CLK_DIV system clock cycles.
- R10: Select pins are active low, one per line. With manual select (0x80) they follow the select register (offset 0x70). Otherwise they follow it only while words are queued or shifting, and are all high when idle.
- R11: Writing the transmit flush bit (0x20) or the receive flush bit (0x40) empties that queue, and the bit reads back as 0.
- R12: No word is shifted unless both enable (0x02) and master (0x04) are set.
- R13: Transmit empty stays 0 while the last word is still shifting, even when its queue is already drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (pops the receive queue at 0x6C) |
| addr | input | ADDR_W | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, valid in the same cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | NUM_SS | Active-low select lines |

## Verification
A register write takes effect at the clock edge inside its strobe cycle. Read data is combinational and is sampled one nanosecond after the falling edge of the read cycle, before the edge that pops. Select pins change one edge after the select or control register changes. After hold is released, the first word loads on the next edge, and the first serial clock edge comes CLK_DIV cycles later. For this reason the bench never samples at a fixed cycle for serial results. It counts sampling edges in a small slave model, polls transmit empty for completion, and measures a half period by counting system edges between two serial clock toggles.

// File: rtl/spi_fifo_master_pkg.sv
package spi_fifo_master_pkg;

  localparam int CTL_W       = 10;
  localparam int CTL_LOOP    = 0;
  localparam int CTL_EN      = 1;
  localparam int CTL_MASTER  = 2;
  localparam int CTL_CPOL    = 3;
  localparam int CTL_CPHA    = 4;
  localparam int CTL_TXFLUSH = 5;
  localparam int CTL_RXFLUSH = 6;
  localparam int CTL_MANSEL  = 7;
  localparam int CTL_HOLD    = 8;
  localparam int CTL_LSB     = 9;

  localparam int OFS_CTRL = 'h60;
  localparam int OFS_STAT = 'h64;
  localparam int OFS_TX   = 'h68;
  localparam int OFS_RX   = 'h6C;
  localparam int OFS_SEL  = 'h70;

  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txFlush;
    logic rxFlush;
  } ctlStrobe_t;

  typedef struct packed {
    logic loop;
    logic cpol;
    logic cpha;
    logic lsbFirst;
    logic run;
  } modeCfg_t;

  typedef struct packed {
    logic rxEmpty;
    logic rxFull;
    logic txEmpty;
    logic txFull;
    logic active;
    logic busy;
  } dpStatus_t;

endpackage

// File: rtl/spi_fifo_master_queue.sv
module spi_fifo_master_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = push & ~full;
  assign doPop  = pop & ~empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= din;
  end
endmodule

// File: rtl/spi_fifo_master_ctrl.sv
module spi_fifo_master_ctrl
  import spi_fifo_master_pkg::*;
#(
  parameter int W      = 8,
  parameter int NUM_SS = 4,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output ctlStrobe_t        strobe,
  output modeCfg_t          mode,
  output logic              manualSel,
  output logic [NUM_SS-1:0] selLines,
  input  dpStatus_t         stat,
  input  logic [W-1:0]      rxHead,
  output logic [NUM_SS-1:0] ssN
);
  localparam logic [CTL_W-1:0] CTL_RESET  = CTL_W'(1 << CTL_HOLD);
  localparam logic [CTL_W-1:0] FLUSH_MASK = CTL_W'((1 << CTL_TXFLUSH) | (1 << CTL_RXFLUSH));

  logic [CTL_W-1:0]  ctlReg;
  logic [NUM_SS-1:0] selReg;
  logic [NUM_SS-1:0] ssReg;
  logic [31:0]       selRead;
  logic hitCtl, hitStat, hitTx, hitRx, hitSel;
  wire  unusedBits = &{1'b0, wrData};

  assign hitCtl  = (addr == ADDR_W'(OFS_CTRL));
  assign hitStat = (addr == ADDR_W'(OFS_STAT));
  assign hitTx   = (addr == ADDR_W'(OFS_TX));
  assign hitRx   = (addr == ADDR_W'(OFS_RX));
  assign hitSel  = (addr == ADDR_W'(OFS_SEL));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg <= CTL_RESET;
      selReg <= '1;
      ssReg  <= '1;
    end else begin
      if (wrEn && hitCtl) ctlReg <= wrData[CTL_W-1:0] & ~FLUSH_MASK;
      if (wrEn && hitSel) selReg <= wrData[NUM_SS-1:0];
      ssReg <= (ctlReg[CTL_MANSEL] || stat.active) ? selReg : '1;
    end
  end

  assign strobe.txPush  = wrEn & hitTx;
  assign strobe.rxPop   = rdEn & hitRx;
  assign strobe.txFlush = wrEn & hitCtl & wrData[CTL_TXFLUSH];
  assign strobe.rxFlush = wrEn & hitCtl & wrData[CTL_RXFLUSH];

  assign mode.loop     = ctlReg[CTL_LOOP];
  assign mode.cpol     = ctlReg[CTL_CPOL];
  assign mode.cpha     = ctlReg[CTL_CPHA];
  assign mode.lsbFirst = ctlReg[CTL_LSB];
  assign mode.run      = ctlReg[CTL_EN] & ctlReg[CTL_MASTER] & ~ctlReg[CTL_HOLD];

  assign manualSel = ctlReg[CTL_MANSEL];
  assign selLines  = selReg;
  assign ssN       = ssReg;

  generate
    if (NUM_SS < 32) begin : g_selPad
      assign selRead = {{(32 - NUM_SS){1'b1}}, selReg};
    end else begin : g_selFull
      assign selRead = selReg;
    end
  endgenerate

  always_comb begin
    rdData = '0;
    if (hitCtl)  rdData = 32'(ctlReg);
    if (hitStat) rdData = {27'b0, 1'b0, stat.txFull, stat.txEmpty, stat.rxFull, stat.rxEmpty};
    if (hitRx)   rdData = stat.rxEmpty ? 32'b0 : 32'(rxHead);
    if (hitSel)  rdData = selRead;
  end
endmodule

// File: rtl/spi_fifo_master_datapath.sv
module spi_fifo_master_datapath
  import spi_fifo_master_pkg::*;
#(
  parameter int W          = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int CLK_DIV    = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctlStrobe_t   strobe,
  input  modeCfg_t     mode,
  input  logic [W-1:0] wrWord,
  input  logic         miso,
  output logic         sclk,
  output logic         mosi,
  output logic [W-1:0] rxHead,
  output dpStatus_t    stat
);
  localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int EDGE_W = $clog2(2 * W);

  logic [W-1:0]      txHead, txOrd, txSh, rxSh, rxShNext, rxWord;
  logic              txEmptyF, txFullF, rxEmptyF, rxFullF;
  logic              busy, sclkR, outBit;
  logic [DIV_W-1:0]  divCnt;
  logic [EDGE_W-1:0] edgeIdx;
  logic              startXfer, halfDone, lastEdge, sampleEdge, inBit;

  spi_fifo_master_queue #(.W(W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .flush(strobe.txFlush), .push(strobe.txPush),
    .din(wrWord), .pop(startXfer), .dout(txHead), .empty(txEmptyF), .full(txFullF)
  );

  spi_fifo_master_queue #(.W(W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .flush(strobe.rxFlush), .push(lastEdge),
    .din(rxWord), .pop(strobe.rxPop), .dout(rxHead), .empty(rxEmptyF), .full(rxFullF)
  );

  assign startXfer  = !busy && mode.run && !txEmptyF;
  assign halfDone   = busy && (divCnt == DIV_W'(CLK_DIV - 1));
  assign lastEdge   = halfDone && (edgeIdx == EDGE_W'(2 * W - 1));
  assign sampleEdge = (edgeIdx[0] == mode.cpha);
  assign inBit      = mode.loop ? outBit : miso;

  always_comb begin
    for (int i = 0; i < W; i++) txOrd[i] = mode.lsbFirst ? txHead[W-1-i] : txHead[i];
    rxShNext = sampleEdge ? {rxSh[W-2:0], inBit} : rxSh;
    for (int i = 0; i < W; i++) rxWord[i] = mode.lsbFirst ? rxShNext[W-1-i] : rxShNext[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sclkR   <= 1'b0;
      outBit  <= 1'b0;
      txSh    <= '0;
      rxSh    <= '0;
      divCnt  <= '0;
      edgeIdx <= '0;
    end else if (!busy) begin
      sclkR   <= mode.cpol;
      divCnt  <= '0;
      edgeIdx <= '0;
      if (startXfer) begin
        busy <= 1'b1;
        rxSh <= '0;
        if (!mode.cpha) begin
          outBit <= txOrd[W-1];
          txSh   <= txOrd << 1;
        end else begin
          txSh   <= txOrd;
        end
      end
    end else if (halfDone) begin
      divCnt  <= '0;
      sclkR   <= ~sclkR;
      edgeIdx <= edgeIdx + 1'b1;
      rxSh    <= rxShNext;
      if (!sampleEdge) begin
        outBit <= txSh[W-1];
        txSh   <= txSh << 1;
      end
      if (lastEdge) busy <= 1'b0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign sclk         = sclkR;
  assign mosi         = outBit;
  assign stat.rxEmpty = rxEmptyF;
  assign stat.rxFull  = rxFullF;
  assign stat.txEmpty = txEmptyF & ~busy;
  assign stat.txFull  = txFullF;
  assign stat.active  = busy | (mode.run & ~txEmptyF);
  assign stat.busy    = busy;
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_master_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int CLK_DIV    = 2,
  parameter int NUM_SS     = 4,
  parameter int ADDR_W     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ssN
);
  ctlStrobe_t        strobe;
  modeCfg_t          mode;
  dpStatus_t         dpStat;
  logic [WORD_W-1:0] rxHead;
  logic              manualW;
  logic [NUM_SS-1:0] selW;
  logic              busyW, runW, cpolW;

  spi_fifo_master_ctrl #(.W(WORD_W), .NUM_SS(NUM_SS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .strobe(strobe), .mode(mode),
    .manualSel(manualW), .selLines(selW), .stat(dpStat), .rxHead(rxHead), .ssN(ssN)
  );

  spi_fifo_master_datapath #(.W(WORD_W), .FIFO_DEPTH(FIFO_DEPTH), .CLK_DIV(CLK_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode(mode), .wrWord(wrData[WORD_W-1:0]),
    .miso(miso), .sclk(sclk), .mosi(mosi), .rxHead(rxHead), .stat(dpStat)
  );

  assign busyW = dpStat.busy;
  assign runW  = mode.run;
  assign cpolW = mode.cpol;
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int CLK_DIV = 2,
  parameter int NUM_SS  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclk,
  input logic [NUM_SS-1:0] ssN,
  input logic              cpol,
  input logic              run,
  input logic              busy,
  input logic              manual,
  input logic [NUM_SS-1:0] sel
);
  // R6: idle serial clock settles at the programmed polarity
  a_r6_idle_polarity: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));

  // R3 / R12: no word starts while shifting is not permitted
  a_r3_no_start_when_halted: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !busy) |=> !busy);

  // R5: a word only starts when the run condition held
  a_r5_start_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(run));

  // R10: manual mode copies the select register onto the pins
  a_r10_manual_follows_reg: assert property (@(posedge clk) disable iff (!rstN)
    $past(manual) |-> (ssN == $past(sel)));

  // R10: automatic mode releases all lines when nothing is pending
  a_r10_auto_idle_deselect: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!manual) && $past(!busy) && $past(!run)) |-> (ssN == '1));

  generate
    if (CLK_DIV > 1) begin : g_spacing
      // R9: a half period is never shorter than two system cycles
      a_r9_half_period_floor: assert property (@(posedge clk) disable iff (!rstN)
        (sclk != $past(sclk)) |=> (sclk == $past(sclk)));
    end
  endgenerate
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.CLK_DIV(CLK_DIV), .NUM_SS(NUM_SS)) u_chk (
  .clk(clk), .rstN(rstN), .sclk(sclk), .ssN(ssN), .cpol(cpolW), .run(runW),
  .busy(busyW), .manual(manualW), .sel(selW)
);

// File: tb/tb_spi_fifo_master.sv
`timescale 1ns/1ps
module tb_spi_fifo_master;
  localparam int W = 8, DEPTH = 4, DIV = 2, NSS = 4, AW = 7;

  typedef struct packed {
    logic cpol; logic cpha; logic lsb; logic loop;
    logic [7:0] tx; logic [7:0] pat;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C},
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'h81, 8'hC3},
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'h5A, 8'h96},
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'h0F, 8'hF0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 8'h01, 8'h80},
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'hD2, 8'hFF}
  };

  logic clk = 0, rstN = 0, wrEn = 0, rdEn = 0, miso;
  logic [AW-1:0] addr = '0;
  logic [31:0] wrData = '0, rdData;
  logic sclk, mosi;
  logic [NSS-1:0] ssN;

  int checks = 0, fails = 0, sampCnt = 0, sclkEdges = 0;
  logic [31:0] capWire = '0;
  logic [7:0] misoPat = '0;
  logic tbCpol = 0, tbCpha = 0, done = 0;

  always #4 clk = ~clk;

  spi_fifo_master #(.WORD_W(W), .FIFO_DEPTH(DEPTH), .CLK_DIV(DIV), .NUM_SS(NSS), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .sclk(sclk), .mosi(mosi), .miso(miso), .ssN(ssN)
  );

  // simple slave: samples on rising edge when cpol==cpha, else falling
  always @(sclk) begin
    sclkEdges++;
    if (sclk == (tbCpol == tbCpha)) begin
      capWire = {capWire[30:0], mosi};
      sampCnt++;
    end
  end
  assign miso = (sampCnt < 8) ? misoPat[7 - (sampCnt % 8)] : 1'b0;

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input int a, input logic [31:0] d);
    @(negedge clk); addr = AW'(a); wrData = d; wrEn = 1;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic busRead(input int a, output logic [31:0] d);
    @(negedge clk); addr = AW'(a); rdEn = 1; #1 d = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic peek(input int a, output logic [31:0] d);
    @(negedge clk); addr = AW'(a); rdEn = 0; #1 d = rdData;
  endtask

  task automatic waitIdle(input string req);
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      peek('h64, s);
      if (s[2]) return;
    end
    chk(req, 32'hDEAD, 32'h0);
  endtask

  task automatic idleCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ctl;
    int n, half;
    idleCycles(3); rstN = 1; idleCycles(2);

    // R1 reset state
    peek('h60, d); chk("R1 ctrl", d, 32'h100);
    peek('h64, d); chk("R1 status", d, 32'h05);
    peek('h70, d); chk("R1 select", d, 32'hFFFF_FFFF);
    chk("R1 ssN", 32'(ssN), 32'hF);
    chk("R1 sclk", 32'(sclk), 0);

    // vector table: mode, order, loopback
    foreach (VECS[k]) begin
      ctl = 32'h6 | (32'(VECS[k].loop) << 0) | (32'(VECS[k].cpol) << 3) |
            (32'(VECS[k].cpha) << 4) | (32'(VECS[k].lsb) << 9);
      tbCpol = VECS[k].cpol; tbCpha = VECS[k].cpha;
      busWrite('h60, ctl | 32'h100);
      idleCycles(2);
      chk("R6 idle polarity", 32'(sclk), 32'(VECS[k].cpol));
      sampCnt = 0; capWire = '0; misoPat = VECS[k].pat;
      busWrite('h68, 32'(VECS[k].tx));
      busWrite('h60, ctl);
      waitIdle("R5 completion");
      chk("R6 sample edges", sampCnt, 8);
      chk("R7 wire order", capWire[7:0], VECS[k].lsb ? rev8(VECS[k].tx) : VECS[k].tx);
      busRead('h6C, d);
      if (VECS[k].loop) chk("R8 loopback", d, 32'(VECS[k].tx));
      else chk("R7 rx order", d, 32'(VECS[k].lsb ? rev8(VECS[k].pat) : VECS[k].pat));
    end
    tbCpol = 0; tbCpha = 0;

    // R2 control readback and status fault bit
    busWrite('h60, 32'h3FF);
    peek('h60, d); chk("R2 ctrl readback", d, 32'h39F);
    peek('h64, d); chk("R2 fault bit", 32'(d[4]), 0);
    busWrite('h60, 32'h106);
    idleCycles(2);

    // R4 depth discovery and R3 hold
    n = 0;
    sclkEdges = 0;
    for (int i = 0; i < 16; i++) begin
      busWrite('h68, 32'(i));
      n++;
      peek('h64, d);
      if (d[3]) break;
    end
    chk("R4 depth", n, DEPTH);
    idleCycles(50);
    chk("R3 no sclk while held", sclkEdges, 0);
    peek('h64, d); chk("R3 tx empty low", 32'(d[2]), 0);

    // R11 transmit flush
    busWrite('h60, 32'h126);
    peek('h60, d); chk("R11 flush reads 0", d, 32'h106);
    peek('h64, d); chk("R11 tx emptied", d, 32'h05);

    // R12 master without enable
    busWrite('h60, 32'h004);
    busWrite('h68, 32'h77);
    sclkEdges = 0;
    idleCycles(40);
    chk("R12 no shift without enable", sclkEdges, 0);
    peek('h64, d); chk("R12 word still queued", 32'(d[2]), 0);
    busWrite('h60, 32'h024);
    peek('h64, d); chk("R11 flushed again", d, 32'h05);

    // R5 back to back, R9 half period, R10 auto select, R13
    busWrite('h70, 32'hE);
    busWrite('h60, 32'h107);
    busWrite('h68, 32'h11); busWrite('h68, 32'h22); busWrite('h68, 32'h33);
    idleCycles(2);
    chk("R10 auto released while held", 32'(ssN), 32'hF);
    sampCnt = 0;
    busWrite('h60, 32'h007);
    @(sclk);
    half = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1; half++;
      if (sclk != tbCpol) continue;
      break;
    end
    chk("R9 half period", half, DIV);
    chk("R10 auto asserted", 32'(ssN), 32'hE);
    wait (sampCnt == 20);
    peek('h64, d); chk("R13 tx empty during last word", 32'(d[2]), 0);
    waitIdle("R5 burst completion");
    chk("R5 edges for three words", sampCnt, 24);
    busRead('h6C, d); chk("R5 rx word 0", d, 32'h11);
    busRead('h6C, d); chk("R5 rx word 1", d, 32'h22);
    busRead('h6C, d); chk("R5 rx word 2", d, 32'h33);
    peek('h64, d); chk("R5 rx empty after", 32'(d[0]), 1);
    idleCycles(2);
    chk("R10 auto released when idle", 32'(ssN), 32'hF);

    // R11 receive flush
    busWrite('h60, 32'h107);
    busWrite('h68, 32'h44);
    busWrite('h60, 32'h007);
    waitIdle("R11 completion");
    busWrite('h60, 32'h146);
    peek('h64, d); chk("R11 rx emptied", 32'(d[0]), 1);

    // R10 manual select
    busWrite('h60, 32'h080);
    busWrite('h70, 32'h5);
    idleCycles(2);
    chk("R10 manual pins", 32'(ssN), 32'h5);
    busWrite('h70, 32'hF);
    idleCycles(2);
    chk("R10 manual deselect", 32'(ssN), 32'hF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule